// File: doc/BRIEF.md
# Dual-Slot Memory Operation Issue Arbiter

This block sits between a small queue of pending memory operations and a data cache that has two access slots per clock. Each clock it looks at the two oldest queued operations and decides whether one, both or neither may go to the cache. Two reads may travel together, or one read with one write. Two writes never share a clock. Granted writes do not reach the cache directly. They are placed in a small in-order write queue that releases one entry per clock whenever the cache accepts it.

Pairing is refused in two cases. The first is a read and a write that hit the same cache set and the same bank. The second is an operation that carries any of five attributes that force it to travel alone. These attributes are an I/O read, a locked access, a segment-descriptor read, a data-breakpoint match and the first half of an access that crosses its natural alignment. A write is held back while the write queue is full, and nothing younger than it is issued in the meantime. A flush discards every queued operation and every buffered write in the same clock.

Operations enter two per clock through two lanes. Lane 0 is older than lane 1. The grant outputs are registered, so an operation that enters an empty queue on one clock edge is granted on the next edge. The cache can then use the data of a granted read in the following clock.

Top module: `memq_dual_issue`

## Requirements
- R1: After reset, both grant valids are 0, the write-queue output valid is 0 and `enq_ready` is 1.
- R2: Two queued reads with no solo attribute are granted in the same clock. Slot 0 carries the older one (lane 0) and slot 1 the younger. Slot 1 is never granted without slot 0.
- R3: Two writes are never granted in one clock. The older write goes alone, and the younger write follows in the next clock.
- R4: A read and a write with equal set index and equal bank are granted in separate clocks. If their banks differ, they are granted together.
- R5: A flag bit in `enq_flags` marks an operation that must travel alone. The bits are 0 I/O read, 1 locked, 2 descriptor read, 3 breakpoint and 4 first misaligned half. An operation with any flag set is never paired, whether it is the older or the younger of the two.
- R6: A write is granted only while the write queue (4 entries) holds fewer than 4 entries. A read older than a stalled write is still granted. The write is granted one clock after an entry leaves the queue.
- R7: The write queue presents the data of granted writes on `wq_*` in grant order. It releases one entry on each clock in which `wq_accept` is 1 and `wq_valid` is 1.
- R8: A flush removes every queued operation and every buffered write. On the next clock `wq_valid` is 0, `enq_ready` is 1, and no flushed operation is ever granted.
- R9: The queue holds at most 4 operations. `enq_ready` is 1 only while at most 2 are held. Operations offered while `enq_ready` is 0 are dropped and are never granted.
- R10: An operation that enters an empty queue at a clock edge, with nothing blocking it, appears on the grant outputs after the following edge and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all queued operations and buffered writes |
| enq_valid | input | 2 | Per-lane offer of a new operation; lane 0 older |
| enq_store | input | 2 | Per-lane: 1 write, 0 read |
| enq_index | input | 2*IDX_W | Per-lane cache set index |
| enq_bank | input | 2*BANK_W | Per-lane cache bank |
| enq_flags | input | 2*FLAG_W | Per-lane solo attributes (see R5) |
| enq_tag | input | 2*TAG_W | Per-lane operation tag |
| enq_data | input | 2*DATA_W | Per-lane write data |
| enq_ready | output | 1 | Queue can take two new operations |
| gnt_valid | output | 2 | Slot grant valids, registered |
| gnt_store | output | 2 | Slot grant is a write |
| gnt_tag | output | 2*TAG_W | Tags of granted operations |
| wq_accept | input | 1 | Cache takes the write at the queue head |
| wq_valid | output | 1 | Write queue head is valid |
| wq_index | output | IDX_W | Head write set index |
| wq_bank | output | BANK_W | Head write bank |
| wq_data | output | DATA_W | Head write data |

## Verification
The assertions assume that `wq_accept` is only acted on while `wq_valid` is high. They also assume that operations are offered only while `enq_ready` is high, except where R9 deliberately offers them while it is low. Every directed scenario starts from an empty queue and drives both lanes in a single clock, so the pair decision is made on a known pair. The stall and drop cases hold `wq_accept` low to keep the write queue full on purpose.

// File: rtl/memq_pkg.sv
package memq_pkg;
  localparam int IDX_W  = 6;
  localparam int BANK_W = 3;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 32;
  localparam int FLAG_W = 5;

  // solo attribute bit positions
  localparam int FL_IO   = 0;
  localparam int FL_LOCK = 1;
  localparam int FL_DESC = 2;
  localparam int FL_BKPT = 3;
  localparam int FL_MIS1 = 4;

  typedef struct packed {
    logic              store;
    logic [IDX_W-1:0]  idx;
    logic [BANK_W-1:0] bank;
    logic [FLAG_W-1:0] flags;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } mem_op_t;

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    logic [BANK_W-1:0] bank;
    logic [DATA_W-1:0] data;
  } wq_ent_t;

  function automatic logic travels_alone(mem_op_t op);
    return |op.flags;
  endfunction
endpackage

// File: rtl/memq_station.sv
module memq_station
  import memq_pkg::*;
#(
  parameter  int SLOTS = 4,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [1:0]        enq_acc,
  input  mem_op_t [1:0]     enq_op,
  input  logic [1:0]        n_issue,
  output mem_op_t [1:0]     head,
  output logic [1:0]        head_v,
  output logic [CNT_W-1:0]  count
);
  mem_op_t          q [SLOTS];
  mem_op_t          d [SLOTS];
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // compact out issued heads, then append accepted lanes in age order
  always_comb begin
    int src;
    int wp;
    for (int i = 0; i < SLOTS; i++) d[i] = q[i];
    for (int i = 0; i < SLOTS; i++) begin
      src = i + int'(n_issue);
      if (src < SLOTS) d[i] = q[src];
    end
    wp = int'(cnt_q) - int'(n_issue);
    for (int l = 0; l < 2; l++) begin
      if (enq_acc[l] && wp < SLOTS) begin
        d[wp] = enq_op[l];
        wp    = wp + 1;
      end
    end
    cnt_d = CNT_W'(wp);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) cnt_q <= '0;
    else              cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) q[i] <= d[i];
  end

  for (genvar h = 0; h < 2; h++) begin : g_head
    assign head[h]   = q[h];
    assign head_v[h] = (cnt_q > CNT_W'(h));
  end

  assign count = cnt_q;

  assert_station_bound_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(SLOTS));
endmodule

// File: rtl/memq_pair_picker.sv
module memq_pair_picker
  import memq_pkg::*;
(
  input  mem_op_t [1:0] head,
  input  logic [1:0]    head_v,
  input  logic          wq_room,
  output logic [1:0]    take
);
  logic a_ok, b_ok, mixed, same_line, both_wr, any_solo;

  always_comb begin
    a_ok      = head_v[0] && (!head[0].store || wq_room);
    mixed     = head[0].store != head[1].store;
    same_line = (head[0].idx == head[1].idx) && (head[0].bank == head[1].bank);
    both_wr   = head[0].store && head[1].store;
    any_solo  = travels_alone(head[0]) || travels_alone(head[1]);
    b_ok      = a_ok && head_v[1] && !both_wr && !any_solo &&
                !(mixed && same_line) && (!head[1].store || wq_room);
    take      = {b_ok, a_ok};
  end
endmodule

// File: rtl/memq_store_queue.sv
module memq_store_queue
  import memq_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    flush,
  input  logic    push,
  input  wq_ent_t push_ent,
  input  logic    pop,
  output wq_ent_t head,
  output logic    not_empty,
  output logic    has_room
);
  wq_ent_t          mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head      = mem[rd_q];
  assign not_empty = (cnt_q != '0);
  assign has_room  = (cnt_q < CNT_W'(DEPTH));

  assert_wq_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt_q < CNT_W'(DEPTH)));
  assert_wq_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/memq_dual_issue.sv
module memq_dual_issue
  import memq_pkg::*;
#(
  parameter int SLOTS    = 4,
  parameter int WQ_DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic [1:0]            enq_valid,
  input  logic [1:0]            enq_store,
  input  logic [2*IDX_W-1:0]    enq_index,
  input  logic [2*BANK_W-1:0]   enq_bank,
  input  logic [2*FLAG_W-1:0]   enq_flags,
  input  logic [2*TAG_W-1:0]    enq_tag,
  input  logic [2*DATA_W-1:0]   enq_data,
  output logic                  enq_ready,
  output logic [1:0]            gnt_valid,
  output logic [1:0]            gnt_store,
  output logic [2*TAG_W-1:0]    gnt_tag,
  input  logic                  wq_accept,
  output logic                  wq_valid,
  output logic [IDX_W-1:0]      wq_index,
  output logic [BANK_W-1:0]     wq_bank,
  output logic [DATA_W-1:0]     wq_data
);
  localparam int CNT_W = $clog2(SLOTS + 1);

  mem_op_t [1:0]    lane_op;
  mem_op_t [1:0]    head;
  logic [1:0]       head_v, take, take_q, store_q, enq_acc, n_issue;
  logic [CNT_W-1:0] st_count;
  logic [2*TAG_W-1:0] tag_q;
  logic             wq_room, wq_push, wq_pop;
  wq_ent_t          wq_in, wq_head;
  mem_op_t          wr_op;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign lane_op[l].store = enq_store[l];
    assign lane_op[l].idx   = enq_index[l*IDX_W +: IDX_W];
    assign lane_op[l].bank  = enq_bank[l*BANK_W +: BANK_W];
    assign lane_op[l].flags = enq_flags[l*FLAG_W +: FLAG_W];
    assign lane_op[l].tag   = enq_tag[l*TAG_W +: TAG_W];
    assign lane_op[l].data  = enq_data[l*DATA_W +: DATA_W];
  end

  assign enq_ready = (st_count <= CNT_W'(SLOTS - 2));
  assign enq_acc   = enq_valid & {2{enq_ready && !flush}};

  memq_station #(.SLOTS(SLOTS)) station_i (
    .clk(clk), .rst(rst), .flush(flush),
    .enq_acc(enq_acc), .enq_op(lane_op), .n_issue(n_issue),
    .head(head), .head_v(head_v), .count(st_count)
  );

  memq_pair_picker picker_i (
    .head(head), .head_v(head_v), .wq_room(wq_room), .take(take)
  );

  // at most one write is granted per clock, so one write port suffices
  assign wr_op   = (take[0] && head[0].store) ? head[0] : head[1];
  assign wq_push = !flush && ((take[0] && head[0].store) || (take[1] && head[1].store));
  assign wq_in   = '{idx: wr_op.idx, bank: wr_op.bank, data: wr_op.data};
  assign wq_pop  = wq_valid && wq_accept && !flush;
  assign n_issue = flush ? 2'd0 : ({1'b0, take[0]} + {1'b0, take[1]});

  memq_store_queue #(.DEPTH(WQ_DEPTH)) wq_i (
    .clk(clk), .rst(rst), .flush(flush),
    .push(wq_push), .push_ent(wq_in), .pop(wq_pop),
    .head(wq_head), .not_empty(wq_valid), .has_room(wq_room)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) take_q <= '0;
    else              take_q <= take;
    for (int s = 0; s < 2; s++) begin
      store_q[s]               <= head[s].store;
      tag_q[s*TAG_W +: TAG_W]  <= head[s].tag;
    end
  end

  assign gnt_valid = take_q;
  assign gnt_store = store_q;
  assign gnt_tag   = tag_q;
  assign wq_index  = wq_head.idx;
  assign wq_bank   = wq_head.bank;
  assign wq_data   = wq_head.data;

  assert_no_write_pair_R3: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid == 2'b11) |-> (gnt_store != 2'b11));
  assert_slot1_after_slot0_R2: assert property (@(posedge clk) disable iff (rst)
    gnt_valid[1] |-> gnt_valid[0]);
  assert_pair_no_solo_R5: assert property (@(posedge clk) disable iff (rst)
    take[1] |-> !(travels_alone(head[0]) || travels_alone(head[1])));
  assert_pair_no_line_clash_R4: assert property (@(posedge clk) disable iff (rst)
    (take[1] && (head[0].store != head[1].store)) |->
      !((head[0].idx == head[1].idx) && (head[0].bank == head[1].bank)));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!wq_valid && enq_ready && gnt_valid == 2'b00));
endmodule

// File: tb/memq_dual_issue_tb_top.sv
`timescale 1ns/1ps
module memq_dual_issue_tb_top;
  import memq_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic [1:0] enq_valid = '0, enq_store = '0;
  logic [2*IDX_W-1:0]  enq_index = '0;
  logic [2*BANK_W-1:0] enq_bank = '0;
  logic [2*FLAG_W-1:0] enq_flags = '0;
  logic [2*TAG_W-1:0]  enq_tag = '0;
  logic [2*DATA_W-1:0] enq_data = '0;
  logic enq_ready;
  logic [1:0] gnt_valid, gnt_store;
  logic [2*TAG_W-1:0] gnt_tag;
  logic wq_accept = 1'b1;
  logic wq_valid;
  logic [IDX_W-1:0] wq_index;
  logic [BANK_W-1:0] wq_bank;
  logic [DATA_W-1:0] wq_data;

  int checks = 0, errors = 0;
  bit done = 0;
  bit mon_en = 0;
  int mon_wr = 0, mon_rd = 0;

  always #2.5 clk = ~clk;

  memq_dual_issue dut_i (
    .clk(clk), .rst(rst), .flush(flush),
    .enq_valid(enq_valid), .enq_store(enq_store), .enq_index(enq_index),
    .enq_bank(enq_bank), .enq_flags(enq_flags), .enq_tag(enq_tag),
    .enq_data(enq_data), .enq_ready(enq_ready),
    .gnt_valid(gnt_valid), .gnt_store(gnt_store), .gnt_tag(gnt_tag),
    .wq_accept(wq_accept), .wq_valid(wq_valid), .wq_index(wq_index),
    .wq_bank(wq_bank), .wq_data(wq_data)
  );

  always @(negedge clk) begin
    if (mon_en) begin
      for (int s = 0; s < 2; s++) begin
        if (gnt_valid[s]) begin
          if (gnt_store[s]) mon_wr++;
          else              mon_rd++;
        end
      end
    end
  end

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic put(int l, bit st, int idx, int bank, int flg, int tag, int dat);
    enq_valid[l] = 1'b1;
    enq_store[l] = st;
    enq_index[l*IDX_W +: IDX_W]   = IDX_W'(idx);
    enq_bank[l*BANK_W +: BANK_W]  = BANK_W'(bank);
    enq_flags[l*FLAG_W +: FLAG_W] = FLAG_W'(flg);
    enq_tag[l*TAG_W +: TAG_W]     = TAG_W'(tag);
    enq_data[l*DATA_W +: DATA_W]  = DATA_W'(dat);
  endtask

  task automatic step_idle();
    @(negedge clk);
    enq_valid = '0;
  endtask

  function automatic int tag0();
    return int'(gnt_tag[TAG_W-1:0]);
  endfunction
  function automatic int tag1();
    return int'(gnt_tag[2*TAG_W-1:TAG_W]);
  endfunction

  task automatic t_reset();
    chk("R1", "gnt_valid", int'(gnt_valid), 0);
    chk("R1", "wq_valid", int'(wq_valid), 0);
    chk("R1", "enq_ready", int'(enq_ready), 1);
  endtask

  task automatic t_two_reads();
    put(0, 0, 5, 1, 0, 1, 0);
    put(1, 0, 5, 1, 0, 2, 0);
    step_idle();
    chk("R10", "no grant one edge after entry", int'(gnt_valid), 0);
    @(negedge clk);
    chk("R2", "pair valid", int'(gnt_valid), 3);
    chk("R2", "slot0 tag", tag0(), 1);
    chk("R2", "slot1 tag", tag1(), 2);
    chk("R2", "both reads", int'(gnt_store), 0);
    @(negedge clk);
    chk("R2", "idle after pair", int'(gnt_valid), 0);
  endtask

  task automatic t_two_writes();
    put(0, 1, 3, 0, 0, 3, 'h30);
    put(1, 1, 7, 2, 0, 4, 'h40);
    step_idle();
    @(negedge clk);
    chk("R3", "first write alone", int'(gnt_valid), 1);
    chk("R3", "first write tag", tag0(), 3);
    @(negedge clk);
    chk("R3", "second write alone", int'(gnt_valid), 1);
    chk("R3", "second write tag", tag0(), 4);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_line_clash();
    put(0, 0, 9, 2, 0, 5, 0);
    put(1, 1, 9, 2, 0, 6, 'h66);
    step_idle();
    @(negedge clk);
    chk("R4", "clash read alone", int'(gnt_valid), 1);
    chk("R4", "clash read tag", tag0(), 5);
    @(negedge clk);
    chk("R4", "clash write next", int'(gnt_valid), 1);
    chk("R4", "clash write tag", tag0(), 6);
    @(negedge clk);
    put(0, 0, 9, 1, 0, 7, 0);
    put(1, 1, 9, 2, 0, 8, 'h88);
    step_idle();
    @(negedge clk);
    chk("R4", "other bank pairs", int'(gnt_valid), 3);
    chk("R4", "other bank kinds", int'(gnt_store), 2);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_solo();
    for (int f = 0; f < FLAG_W; f++) begin
      put(0, 0, 1, 0, 1 << f, 1, 0);
      put(1, 0, 2, 1, 0, 2, 0);
      step_idle();
      @(negedge clk);
      chk("R5", $sformatf("flag %0d older alone", f), int'(gnt_valid), 1);
      chk("R5", $sformatf("flag %0d older tag", f), tag0(), 1);
      @(negedge clk);
      chk("R5", $sformatf("flag %0d younger alone", f), int'(gnt_valid), 1);
      chk("R5", $sformatf("flag %0d younger tag", f), tag0(), 2);
      @(negedge clk);
    end
    put(0, 0, 1, 0, 0, 3, 0);
    put(1, 0, 2, 1, 1 << FL_BKPT, 4, 0);
    step_idle();
    @(negedge clk);
    chk("R5", "flag on younger blocks pair", int'(gnt_valid), 1);
    @(negedge clk);
    chk("R5", "flagged younger next", tag0(), 4);
    @(negedge clk);
  endtask

  task automatic fill_wq();
    wq_accept = 1'b0;
    for (int p = 0; p < 2; p++) begin
      put(0, 1, 10 + 2*p, 0, 0, 1, 'h101 + 2*p);
      put(1, 1, 11 + 2*p, 0, 0, 2, 'h102 + 2*p);
      step_idle();
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_wq_full();
    fill_wq();
    chk("R7", "head holds first write", int'(wq_data), 'h101);
    put(0, 0, 1, 0, 0, 9, 0);
    put(1, 1, 2, 0, 0, 10, 'h1AA);
    step_idle();
    @(negedge clk);
    chk("R6", "older read passes", int'(gnt_valid), 1);
    chk("R6", "older read kind", int'(gnt_store[0]), 0);
    chk("R6", "older read tag", tag0(), 9);
    @(negedge clk);
    chk("R6", "write stalls 1", int'(gnt_valid), 0);
    @(negedge clk);
    chk("R6", "write stalls 2", int'(gnt_valid), 0);
    wq_accept = 1'b1;
    @(negedge clk);
    wq_accept = 1'b0;
    chk("R7", "one entry released", int'(wq_data), 'h102);
    chk("R6", "no grant in release clock", int'(gnt_valid), 0);
    @(negedge clk);
    chk("R6", "write granted after room", int'(gnt_valid), 1);
    chk("R6", "granted write tag", tag0(), 10);
    begin
      int exp_d [4] = '{'h102, 'h103, 'h104, 'h1AA};
      wq_accept = 1'b1;
      for (int k = 0; k < 4; k++) begin
        chk("R7", $sformatf("drain order %0d", k), int'(wq_data), exp_d[k]);
        @(negedge clk);
      end
    end
    chk("R7", "drained empty", int'(wq_valid), 0);
  endtask

  task automatic t_station_full();
    fill_wq();
    put(0, 1, 20, 0, 0, 1, 'h201);
    put(1, 1, 21, 0, 0, 2, 'h202);
    step_idle();
    chk("R9", "ready with two held", int'(enq_ready), 1);
    put(0, 1, 22, 0, 0, 3, 'h203);
    put(1, 1, 23, 0, 0, 4, 'h204);
    step_idle();
    chk("R9", "not ready when full", int'(enq_ready), 0);
    put(0, 0, 30, 0, 0, 7, 0);
    put(1, 0, 31, 0, 0, 8, 0);
    step_idle();
    mon_wr = 0;
    mon_rd = 0;
    mon_en = 1;
    wq_accept = 1'b1;
    repeat (30) @(negedge clk);
    mon_en = 0;
    chk("R9", "held writes granted", mon_wr, 4);
    chk("R9", "dropped reads never granted", mon_rd, 0);
  endtask

  task automatic t_flush();
    wq_accept = 1'b0;
    put(0, 1, 40, 0, 0, 1, 'h401);
    put(1, 1, 41, 0, 0, 2, 'h402);
    step_idle();
    @(negedge clk);
    chk("R8", "write buffered before flush", int'(wq_valid), 1);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk("R8", "write queue empty", int'(wq_valid), 0);
    chk("R8", "ready after flush", int'(enq_ready), 1);
    chk("R8", "no grant at flush", int'(gnt_valid), 0);
    @(negedge clk);
    chk("R8", "flushed write not granted 1", int'(gnt_valid), 0);
    @(negedge clk);
    chk("R8", "flushed write not granted 2", int'(gnt_valid), 0);
    wq_accept = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_two_reads();
    t_two_writes();
    t_line_clash();
    t_solo();
    t_wq_full();
    t_station_full();
    t_flush();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule